// File: doc/BRIEF.md
# Mode-Configurable Two-Port Synchronous RAM

This block is a word-organised synchronous memory with two access ports, A and B, on one clock. Each port registers its address, write data, write strobe, byte lanes and read strobe on the clock edge. On the following edge it updates the addressed word and, when its registered read strobe is set, loads its read register. A build-time mode chooses how the ports are used. In single-port mode, A reads and writes and B is absent. In simple dual-port mode, A only writes and B only reads. In true dual-port mode, both ports read and write. In ROM mode, both ports only read.

Each port also has a hold input that freezes its address register. Write data, strobes and byte lanes keep being sampled while the address is frozen. The memory contents have no load path. Reset fills every word with a computed pattern, so the ROM mode returns known data.

Top module: `cfg_dual_ram`

## Requirements
- R1: Inputs presented before clock edge N are registered at edge N. The read result for that address is visible on the port's read output after edge N+1.
- R2: When a port's registered read strobe is low, that port's read output keeps its previous value.
- R3: While a port's hold input is high at an edge, that port's registered address keeps its previous value. Reads and writes then use the held address.
- R4: The hold input affects only the address register. Write data, write strobe and byte lanes are still sampled at every edge.
- R5: Byte lane k (bit k of the byte-enable input) controls data bits 8k+7 down to 8k. A write changes only the enabled lanes of the addressed word.
- R6: A read and a write in the same cycle on the same address return the word as it was before that write.
- R7: When both ports write the same address in the same cycle, B's data wins on every lane B enables. Lanes enabled only by A take A's data.
- R8: A write to an address at or beyond DEPTH changes nothing. A read of such an address returns zero.
- R9: In ROM mode, writes on either port have no effect, and both ports can read.
- R10: In single-port mode, port A reads and writes. Port B's read output stays zero and port B's writes have no effect.
- R11: In simple dual-port mode, only port A writes and only port B reads. Port A's read output stays zero and port B's write inputs are ignored.
- R12: In true dual-port mode, both ports can read and write.
- R13: After reset, all registers and read outputs are zero. Each word w holds byte k equal to (w*DATA_W/8 + k) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_we | input | 1 | Port A write strobe |
| a_be | input | DATA_W/8 | Port A byte lanes |
| a_re | input | 1 | Port A read strobe |
| a_hold | input | 1 | Port A address freeze |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_we | input | 1 | Port B write strobe |
| b_be | input | DATA_W/8 | Port B byte lanes |
| b_re | input | 1 | Port B read strobe |
| b_hold | input | 1 | Port B address freeze |
| a_rdata | output | DATA_W | Port A read output |
| b_rdata | output | DATA_W | Port B read output |

## Verification
Inputs driven before edge N are registered at N. Memory updates and read outputs are therefore due just after edge N+1, two edges after the stimulus. The bench keeps its own copy of the input registers and one memory image per mode instance. At each falling edge it first computes the read results from the registers held since the previous edge. It then applies that cycle's writes, loads its registers from the inputs that the last edge sampled, and only after that compares all read outputs. This way every comparison falls exactly one cycle after the read strobe was registered.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE      = 2'd0,
    MODE_SIMPLE_DUAL = 2'd1,
    MODE_TRUE_DUAL   = 2'd2,
    MODE_ROM         = 2'd3
  } ram_mode_e;

  // can the port (is_b selects B) produce read data in this mode
  function automatic logic port_reads(ram_mode_e m, logic is_b);
    case (m)
      MODE_SINGLE:      return !is_b;
      MODE_SIMPLE_DUAL: return is_b;
      default:          return 1'b1;
    endcase
  endfunction

  // can the port write in this mode
  function automatic logic port_writes(ram_mode_e m, logic is_b);
    case (m)
      MODE_SINGLE, MODE_SIMPLE_DUAL: return !is_b;
      MODE_TRUE_DUAL:                return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dpram_port_reg.sv
module dpram_port_reg #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int BE_W    = DATA_W / 8,
  parameter bit RD_LIVE = 1'b1,
  parameter bit WR_LIVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [BE_W-1:0]   be,
  input  logic              re,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              we_q,
  output logic [BE_W-1:0]   be_q,
  output logic              re_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      re_q    <= 1'b0;
    end else begin
      if (!hold) addr_q <= addr;
      wdata_q <= wdata;
      be_q    <= be;
      we_q    <= WR_LIVE ? we : 1'b0;
      re_q    <= RD_LIVE ? re : 1'b0;
    end
  end

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> addr_q == $past(addr_q));

  assert_data_sampled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> wdata_q == $past(wdata));

endmodule

// File: rtl/dpram_storage.sv
module dpram_storage #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 24,
  parameter bit RD_A     = 1'b1,
  parameter bit RD_B     = 1'b1,
  parameter bit ROM_MODE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_a,
  input  logic [DATA_W-1:0]     wdata_a,
  input  logic                  we_a,
  input  logic [DATA_W/8-1:0]   be_a,
  input  logic                  re_a,
  input  logic [ADDR_W-1:0]     addr_b,
  input  logic [DATA_W-1:0]     wdata_b,
  input  logic                  we_b,
  input  logic [DATA_W/8-1:0]   be_b,
  input  logic                  re_b,
  output logic [DATA_W-1:0]     q_a,
  output logic [DATA_W-1:0]     q_b
);

  localparam int NB    = DATA_W / 8;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic in_range(logic [ADDR_W-1:0] a);
    return 32'(a) < 32'(DEPTH);
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(logic [NB-1:0] be);
    logic [DATA_W-1:0] m;
    for (int k = 0; k < NB; k++) m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] seed_word(int w);
    logic [DATA_W-1:0] v;
    for (int k = 0; k < NB; k++) v[k*8 +: 8] = 8'(w * NB + k);
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old_w,
                                              logic [DATA_W-1:0] new_w,
                                              logic [DATA_W-1:0] m);
    return (old_w & ~m) | (new_w & m);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  logic [IDX_W-1:0]  idx_a, idx_b;
  logic [DATA_W-1:0] mask_a, mask_b;
  logic              wr_fire_a, wr_fire_b, collide;
  logic [DATA_W-1:0] word_a, word_b;

  assign idx_a     = addr_a[IDX_W-1:0];
  assign idx_b     = addr_b[IDX_W-1:0];
  assign mask_a    = lane_mask(be_a);
  assign mask_b    = lane_mask(be_b);
  assign wr_fire_a = we_a && in_range(addr_a);
  assign wr_fire_b = we_b && in_range(addr_b);
  assign collide   = wr_fire_a && wr_fire_b && (addr_a == addr_b);
  assign word_a    = merge(mem[idx_a], wdata_a, mask_a);
  assign word_b    = merge(collide ? word_a : mem[idx_b], wdata_b, mask_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= seed_word(w);
    end else begin
      if (wr_fire_a) mem[idx_a] <= word_a;
      if (wr_fire_b) mem[idx_b] <= word_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a <= '0;
      q_b <= '0;
    end else begin
      if (re_a) q_a <= in_range(addr_a) ? mem[idx_a] : '0;
      if (re_b) q_b <= in_range(addr_b) ? mem[idx_b] : '0;
    end
  end

  assert_hold_q_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !re_a |=> $stable(q_a));
  assert_hold_q_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !re_b |=> $stable(q_b));

  assert_oob_zero_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (re_a && !in_range(addr_a)) |=> q_a == '0);
  assert_oob_zero_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (re_b && !in_range(addr_b)) |=> q_b == '0);

  assert_old_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (re_a && wr_fire_a) |=> q_a == $past(mem[idx_a]));

  assert_b_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (mem[$past(idx_b)] & $past(mask_b)) == ($past(wdata_b) & $past(mask_b)));

  assert_rom_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ROM_MODE |-> !(wr_fire_a || wr_fire_b));

  if (!RD_A) begin : g_idle_a
    assert_idle_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
      q_a == '0);
  end
  if (!RD_B) begin : g_idle_b
    assert_idle_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
      q_b == '0);
  end

endmodule

// File: rtl/cfg_dual_ram.sv
module cfg_dual_ram
  import dpram_pkg::*;
#(
  parameter ram_mode_e MODE   = MODE_TRUE_DUAL,
  parameter int        ADDR_W = 5,
  parameter int        DEPTH  = 24,
  parameter int        DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic [DATA_W-1:0]   a_wdata,
  input  logic                a_we,
  input  logic [DATA_W/8-1:0] a_be,
  input  logic                a_re,
  input  logic                a_hold,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic [DATA_W-1:0]   b_wdata,
  input  logic                b_we,
  input  logic [DATA_W/8-1:0] b_be,
  input  logic                b_re,
  input  logic                b_hold,
  output logic [DATA_W-1:0]   a_rdata,
  output logic [DATA_W-1:0]   b_rdata
);

  localparam int BE_W  = DATA_W / 8;
  localparam bit RD_A  = port_reads(MODE, 1'b0);
  localparam bit RD_B  = port_reads(MODE, 1'b1);
  localparam bit WR_A  = port_writes(MODE, 1'b0);
  localparam bit WR_B  = port_writes(MODE, 1'b1);
  localparam bit IS_ROM = (MODE == MODE_ROM);

  logic [ADDR_W-1:0] ra_addr, rb_addr;
  logic [DATA_W-1:0] ra_wdata, rb_wdata;
  logic              ra_we, rb_we, ra_re, rb_re;
  logic [BE_W-1:0]   ra_be, rb_be;

  dpram_port_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
                   .RD_LIVE(RD_A), .WR_LIVE(WR_A)) u_port_a (
    .clk(clk), .rst_n(rst_n), .hold(a_hold), .addr(a_addr), .wdata(a_wdata),
    .we(a_we), .be(a_be), .re(a_re),
    .addr_q(ra_addr), .wdata_q(ra_wdata), .we_q(ra_we), .be_q(ra_be), .re_q(ra_re));

  dpram_port_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
                   .RD_LIVE(RD_B), .WR_LIVE(WR_B)) u_port_b (
    .clk(clk), .rst_n(rst_n), .hold(b_hold), .addr(b_addr), .wdata(b_wdata),
    .we(b_we), .be(b_be), .re(b_re),
    .addr_q(rb_addr), .wdata_q(rb_wdata), .we_q(rb_we), .be_q(rb_be), .re_q(rb_re));

  dpram_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
                  .RD_A(RD_A), .RD_B(RD_B), .ROM_MODE(IS_ROM)) u_store (
    .clk(clk), .rst_n(rst_n),
    .addr_a(ra_addr), .wdata_a(ra_wdata), .we_a(ra_we), .be_a(ra_be), .re_a(ra_re),
    .addr_b(rb_addr), .wdata_b(rb_wdata), .we_b(rb_we), .be_b(rb_be), .re_b(rb_re),
    .q_a(a_rdata), .q_b(b_rdata));

endmodule

// File: tb/tb_cfg_dual_ram.sv
`timescale 1ns/1ps
module tb_cfg_dual_ram;
  import dpram_pkg::*;

  localparam int AW = 5;
  localparam int DEP = 24;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic          a_we = 0, b_we = 0, a_re = 0, b_re = 0, a_hold = 0, b_hold = 0;
  logic [3:0]    a_be = '0, b_be = '0;
  logic [DW-1:0] qa [4];
  logic [DW-1:0] qb [4];

  // index 0 single, 1 simple dual, 2 true dual, 3 ROM
  cfg_dual_ram #(.MODE(MODE_SINGLE), .ADDR_W(AW), .DEPTH(DEP), .DATA_W(DW)) dut_single (
    .clk, .rst_n, .a_addr, .a_wdata, .a_we, .a_be, .a_re, .a_hold,
    .b_addr, .b_wdata, .b_we, .b_be, .b_re, .b_hold, .a_rdata(qa[0]), .b_rdata(qb[0]));
  cfg_dual_ram #(.MODE(MODE_SIMPLE_DUAL), .ADDR_W(AW), .DEPTH(DEP), .DATA_W(DW)) dut_sdp (
    .clk, .rst_n, .a_addr, .a_wdata, .a_we, .a_be, .a_re, .a_hold,
    .b_addr, .b_wdata, .b_we, .b_be, .b_re, .b_hold, .a_rdata(qa[1]), .b_rdata(qb[1]));
  cfg_dual_ram #(.MODE(MODE_TRUE_DUAL), .ADDR_W(AW), .DEPTH(DEP), .DATA_W(DW)) dut (
    .clk, .rst_n, .a_addr, .a_wdata, .a_we, .a_be, .a_re, .a_hold,
    .b_addr, .b_wdata, .b_we, .b_be, .b_re, .b_hold, .a_rdata(qa[2]), .b_rdata(qb[2]));
  cfg_dual_ram #(.MODE(MODE_ROM), .ADDR_W(AW), .DEPTH(DEP), .DATA_W(DW)) dut_rom (
    .clk, .rst_n, .a_addr, .a_wdata, .a_we, .a_be, .a_re, .a_hold,
    .b_addr, .b_wdata, .b_we, .b_be, .b_re, .b_hold, .a_rdata(qa[3]), .b_rdata(qb[3]));

  localparam bit A_RD [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
  localparam bit B_RD [4] = '{1'b0, 1'b1, 1'b1, 1'b1};
  localparam bit A_WR [4] = '{1'b1, 1'b1, 1'b1, 1'b0};
  localparam bit B_WR [4] = '{1'b0, 1'b0, 1'b1, 1'b0};
  string inst_tag [4] = '{"R10", "R11", "R12", "R9"};

  int checks = 0;
  int fails  = 0;
  string phase = "R13";
  bit done = 0;

  logic [DW-1:0] mdl [4][DEP];
  logic [DW-1:0] eqa [4];
  logic [DW-1:0] eqb [4];
  logic [AW-1:0] r_aa, r_ab;
  logic [DW-1:0] r_ad, r_bd;
  logic          r_awe, r_bwe, r_are, r_bre;
  logic [3:0]    r_abe, r_bbe;

  function automatic logic [DW-1:0] ref_seed(int w);
    logic [7:0] base = 8'(w << 2);
    return {base | 8'd3, base | 8'd2, base | 8'd1, base};
  endfunction

  function automatic logic [DW-1:0] ref_merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [3:0] be);
    logic [DW-1:0] r = o;
    if (be[0]) r[7:0]   = n[7:0];
    if (be[1]) r[15:8]  = n[15:8];
    if (be[2]) r[23:16] = n[23:16];
    if (be[3]) r[31:24] = n[31:24];
    return r;
  endfunction

  task automatic cmp(string port, int m, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s/%s mode%0d port %s: got %h expected %h", phase, inst_tag[m], m, port, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst_n) begin
      for (int m = 0; m < 4; m++) begin
        for (int w = 0; w < DEP; w++) mdl[m][w] = ref_seed(w);
        eqa[m] = '0; eqb[m] = '0;
      end
      r_aa = '0; r_ab = '0; r_ad = '0; r_bd = '0; r_abe = '0; r_bbe = '0;
      r_awe = 0; r_bwe = 0; r_are = 0; r_bre = 0;
    end else begin
      for (int m = 0; m < 4; m++) begin
        if (A_RD[m] && r_are) eqa[m] = (int'(r_aa) < DEP) ? mdl[m][r_aa] : '0;
        if (B_RD[m] && r_bre) eqb[m] = (int'(r_ab) < DEP) ? mdl[m][r_ab] : '0;
        if (A_WR[m] && r_awe && int'(r_aa) < DEP) mdl[m][r_aa] = ref_merge(mdl[m][r_aa], r_ad, r_abe);
        if (B_WR[m] && r_bwe && int'(r_ab) < DEP) mdl[m][r_ab] = ref_merge(mdl[m][r_ab], r_bd, r_bbe);
      end
      if (!a_hold) r_aa = a_addr;
      if (!b_hold) r_ab = b_addr;
      r_ad = a_wdata; r_bd = b_wdata; r_awe = a_we; r_bwe = b_we;
      r_abe = a_be; r_bbe = b_be; r_are = a_re; r_bre = b_re;
    end
    for (int m = 0; m < 4; m++) begin
      cmp("A", m, qa[m], eqa[m]);
      cmp("B", m, qb[m], eqb[m]);
    end
  endtask

  task automatic idle();
    a_we = 0; b_we = 0; a_re = 0; b_re = 0; a_hold = 0; b_hold = 0;
  endtask

  task automatic rd(logic [AW-1:0] aa, logic [AW-1:0] ab);
    idle(); a_addr = aa; b_addr = ab; a_re = 1; b_re = 1;
    tick();
  endtask

  task automatic wr(bit on_a, logic [AW-1:0] ad, logic [DW-1:0] d, logic [3:0] be);
    idle();
    if (on_a) begin a_addr = ad; a_wdata = d; a_be = be; a_we = 1; end
    else begin b_addr = ad; b_wdata = d; b_be = be; b_we = 1; end
    tick();
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240611);
    // R13: reset state and seeded contents
    phase = "R13";
    repeat (3) tick();
    rst_n = 1'b1;
    for (int w = 0; w < DEP; w++) rd(AW'(w), AW'(DEP - 1 - w));
    idle(); tick(); tick();

    // R1: read latency with a changing address stream
    phase = "R1";
    for (int w = 0; w < 8; w++) rd(AW'(w * 3 % DEP), AW'(w));
    idle(); tick(); tick();

    // R5: byte lanes, lane k covers bits 8k+7..8k
    phase = "R5";
    wr(1, 5'd3, 32'hAABBCCDD, 4'b0101);
    wr(0, 5'd4, 32'h11223344, 4'b1000);
    wr(1, 5'd6, 32'hFFFFFFFF, 4'b0000);
    rd(5'd3, 5'd4); rd(5'd6, 5'd3); idle(); tick(); tick();

    // R2: read strobe low keeps output while address moves
    phase = "R2";
    rd(5'd2, 5'd2);
    for (int i = 0; i < 4; i++) begin idle(); a_addr = AW'(i + 8); b_addr = AW'(i + 9); tick(); end
    tick();

    // R3: address held, reads keep the frozen address
    phase = "R3";
    rd(5'd5, 5'd7);
    a_hold = 1; b_hold = 1; a_addr = 5'd9; b_addr = 5'd10; tick(); tick(); tick();
    // R4: write while held lands on the held address with fresh data
    phase = "R4";
    a_re = 0; b_re = 0; a_we = 1; a_wdata = 32'h0BADF00D; a_be = 4'hF; tick();
    a_we = 0; a_wdata = 32'h12345678; a_re = 1; b_re = 1; tick();
    idle(); rd(5'd5, 5'd9); rd(5'd10, 5'd5); idle(); tick(); tick();

    // R6: same-port read during write returns old word
    phase = "R6";
    idle(); a_addr = 5'd11; a_wdata = 32'hCAFEBABE; a_be = 4'hF; a_we = 1; a_re = 1;
    b_addr = 5'd11; b_re = 1; tick();
    rd(5'd11, 5'd11); idle(); tick(); tick();

    // R7: collision on one address, B wins on its lanes
    phase = "R7";
    idle(); a_addr = 5'd7; b_addr = 5'd7; a_wdata = 32'hA1A2A3A4; b_wdata = 32'hB1B2B3B4;
    a_be = 4'b1111; b_be = 4'b0011; a_we = 1; b_we = 1; tick();
    rd(5'd7, 5'd7); idle(); tick(); tick();

    // R8: out-of-range writes dropped, reads return zero
    phase = "R8";
    wr(1, 5'd30, 32'hDEADDEAD, 4'hF);
    wr(0, 5'd24, 32'hDEADDEAD, 4'hF);
    rd(5'd30, 5'd24); rd(5'd23, 5'd31); rd(5'd0, 5'd8); idle(); tick(); tick();

    // random mix: all modes, R9 R10 R11 R12 per instance
    phase = "R12";
    for (int i = 0; i < 3000; i++) begin
      a_addr  = AW'($urandom_range(0, 31));
      b_addr  = ($urandom_range(0, 3) == 0) ? a_addr : AW'($urandom_range(0, 31));
      a_wdata = $urandom(); b_wdata = $urandom();
      a_be    = 4'($urandom()); b_be = 4'($urandom());
      a_we    = $urandom_range(0, 2) == 0; b_we = $urandom_range(0, 2) == 0;
      a_re    = $urandom_range(0, 3) != 0; b_re = $urandom_range(0, 3) != 0;
      a_hold  = $urandom_range(0, 7) == 0; b_hold = $urandom_range(0, 7) == 0;
      tick();
    end
    idle(); tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule